// File: doc/BRIEF.md
# Transport Stream Sync Monitor

This block watches a byte-aligned MPEG-2 transport stream and reports how healthy it is. Bytes arrive with a one-cycle valid strobe. The block searches for the packet start byte, 0x47, and learns whether packets repeat every 188 or every 204 bytes. It then tracks that grid. A sync error is declared only after repeated misses and is withdrawn only after a run of good packets. A separate serial bit tap feeds an activity watch, which declares the input lost when the line stops toggling.

The outputs are four indicators: 188-byte framing, 204-byte framing, sync error and input loss. There is also a combined alarm and an enable for the downstream line driver. The sync-error indicator is stretched after the error clears so that a short clear stays visible. The length of this stretch is a parameter counted in clock cycles.

The sync tracker state machine has four states:

- `TRK_HUNT`: no reference yet. The next 0x47 moves the machine to `TRK_PROBE`.
- `TRK_PROBE`: a reference sync has been taken. A 0x47 at offset 188 or 204 selects that length and moves to `TRK_CONFIRM`. A non-sync byte at offset 204 returns to `TRK_HUNT`.
- `TRK_CONFIRM`: each sync at the expected offset counts as a hit. The fifth hit clears the error and moves to `TRK_LOCK`. Any miss returns to `TRK_HUNT`.
- `TRK_LOCK`: a sync at the expected offset resets the miss count. The second consecutive miss raises the error and returns to `TRK_HUNT`.

The activity watch has two states. It moves from `ACT_LIVE` to `ACT_LOST` when the run of identical bits reaches its limit. It moves from `ACT_LOST` back to `ACT_LIVE` on the first bit that differs from the one before it.

The hold stretch has three states. It moves from `HLD_FAULT` to `HLD_TAIL` when the error drops. It moves from `HLD_TAIL` to `HLD_QUIET` when the countdown expires. It returns to `HLD_FAULT` from `HLD_TAIL` or `HLD_QUIET` whenever the error rises.

Top module: `ts_health_monitor`

## Requirements
- R1: Only the byte value 0x47 counts as a sync. While hunting, the first 0x47 seen becomes the reference, and the next sync is then looked for at byte offset 188 or 204 from it (the reference itself counts as offset 0).
- R2: `ind_188` is high while the tracker is locked on a 188-byte spacing.
- R3: `ind_204` is high while the tracker is locked on a 204-byte spacing, including when 188-offset bytes are data.
- R4: While locked, two consecutive expected sync positions without 0x47 raise the sync error. A single miss followed by a hit does not raise it.
- R5: The sync error is raised at reset. It clears on the clock edge that takes the fifth consecutive sync at the chosen spacing after the reference.
- R6: `ind_sync_err` is high while the error is active and for HOLD_CYCLES clock cycles after it clears, then goes low.
- R7: `ind_in_loss` rises after RUN_LIMIT consecutive identical tap bits (all ones or all zeros) and not after RUN_LIMIT-1.
- R8: Input loss stays active for runs longer than RUN_LIMIT, because the run counter saturates. It clears on the first tap bit that differs from the one before it.
- R9: `alarm` is high exactly when the sync error (unstretched) or input loss is active.
- R10: `line_oe` is low exactly while input loss is active.
- R11: Both length indicators are low whenever the sync error or input loss is active.
- R12: After reset, `alarm` and `ind_sync_err` are high, while `ind_188`, `ind_204` and `ind_in_loss` are low and `line_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | Stream byte valid strobe |
| byte_in | input | 8 | Stream byte |
| bit_vld | input | 1 | Serial tap bit valid |
| bit_in | input | 1 | Serial tap bit |
| ind_188 | output | 1 | Locked on 188-byte packets |
| ind_204 | output | 1 | Locked on 204-byte packets |
| ind_sync_err | output | 1 | Stretched sync-error indicator |
| ind_in_loss | output | 1 | Input loss indicator |
| alarm | output | 1 | Sync error or input loss |
| line_oe | output | 1 | Downstream line stage enable |

## Verification
The bench sets HOLD_CYCLES to 20 so that the post-clear stretch can be timed to the exact cycle, both its last lit cycle and its first dark one. RUN_LIMIT stays at its default of 2040. This keeps the exact loss threshold in reach, and a run of 2100 bits pushes the counter past the 2048 point where an 11-bit counter would wrap without saturation. The packet lengths stay at 188 and 204, so the bench can check both spacings, the learning of 204 over data bytes sitting at offset 188, and the raise and clear hysteresis at full packet size.

// File: rtl/ts_mon_pkg.sv
package ts_mon_pkg;

    typedef enum logic [1:0] {
        TRK_HUNT,
        TRK_PROBE,
        TRK_CONFIRM,
        TRK_LOCK
    } trk_state_t;

    typedef enum logic {
        ACT_LIVE,
        ACT_LOST
    } act_state_t;

    typedef enum logic [1:0] {
        HLD_QUIET,
        HLD_FAULT,
        HLD_TAIL
    } hld_state_t;

    typedef enum logic {
        SPAN_SHORT,
        SPAN_LONG
    } span_t;

endpackage

// File: rtl/ts_sync_tracker.sv
module ts_sync_tracker
    import ts_mon_pkg::*;
#(
    parameter logic [7:0] SYNC_BYTE  = 8'h47,
    parameter int         LEN_SHORT  = 188,
    parameter int         LEN_LONG   = 204,
    parameter int         MISS_LIMIT = 2,
    parameter int         HIT_LIMIT  = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    output logic       sync_err,
    output logic       locked,
    output logic       span_long
);

    localparam int CW = $clog2(LEN_LONG + 1);
    localparam int HW = $clog2(HIT_LIMIT + 1);
    localparam int MW = $clog2(MISS_LIMIT + 1);
    localparam logic [CW-1:0] SHORT_C  = CW'(LEN_SHORT);
    localparam logic [CW-1:0] LONG_C   = CW'(LEN_LONG);
    localparam logic [CW-1:0] ONE_C    = CW'(1);
    localparam logic [HW-1:0] HIT_TOP  = HW'(HIT_LIMIT - 1);
    localparam logic [MW-1:0] MISS_TOP = MW'(MISS_LIMIT - 1);

    trk_state_t    state, nxt;
    span_t         span, span_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [HW-1:0] hits, hits_n;
    logic [MW-1:0] miss, miss_n;
    logic          err_n;
    logic          is_sync;
    logic [CW-1:0] exp_len;

    assign is_sync = (byte_in == SYNC_BYTE);
    assign exp_len = (span == SPAN_LONG) ? LONG_C : SHORT_C;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= TRK_HUNT;
            span     <= SPAN_SHORT;
            cnt      <= '0;
            hits     <= '0;
            miss     <= '0;
            sync_err <= 1'b1;
        end else begin
            state    <= nxt;
            span     <= span_n;
            cnt      <= cnt_n;
            hits     <= hits_n;
            miss     <= miss_n;
            sync_err <= err_n;
        end
    end

    always_comb begin
        nxt    = state;
        span_n = span;
        cnt_n  = cnt;
        hits_n = hits;
        miss_n = miss;
        err_n  = sync_err;
        if (byte_vld) begin
            cnt_n = cnt + ONE_C;
            unique case (state)
                TRK_HUNT: begin
                    if (is_sync) begin
                        nxt    = TRK_PROBE;
                        cnt_n  = ONE_C;
                        hits_n = '0;
                    end
                end
                TRK_PROBE: begin
                    if (cnt == SHORT_C && is_sync) begin
                        nxt    = TRK_CONFIRM;
                        span_n = SPAN_SHORT;
                        cnt_n  = ONE_C;
                        hits_n = HW'(1);
                    end else if (cnt == LONG_C) begin
                        if (is_sync) begin
                            nxt    = TRK_CONFIRM;
                            span_n = SPAN_LONG;
                            cnt_n  = ONE_C;
                            hits_n = HW'(1);
                        end else begin
                            nxt = TRK_HUNT;
                        end
                    end
                end
                TRK_CONFIRM: begin
                    if (cnt == exp_len) begin
                        cnt_n = ONE_C;
                        if (!is_sync) begin
                            nxt = TRK_HUNT;
                        end else if (hits == HIT_TOP) begin
                            nxt    = TRK_LOCK;
                            err_n  = 1'b0;
                            miss_n = '0;
                        end else begin
                            hits_n = hits + HW'(1);
                        end
                    end
                end
                TRK_LOCK: begin
                    if (cnt == exp_len) begin
                        cnt_n = ONE_C;
                        if (is_sync) begin
                            miss_n = '0;
                        end else if (miss == MISS_TOP) begin
                            nxt   = TRK_HUNT;
                            err_n = 1'b1;
                        end else begin
                            miss_n = miss + MW'(1);
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        locked    = (state == TRK_LOCK);
        span_long = (span == SPAN_LONG);
    end

    AST_ERR_RISE_FROM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err) |-> ($past(state) == TRK_LOCK && $past(byte_vld))); // R4

    AST_ERR_FALL_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_err) |-> $past(state == TRK_CONFIRM && byte_vld && byte_in == SYNC_BYTE)); // R5

    AST_LOCK_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRK_LOCK) |-> !sync_err); // R11

endmodule

// File: rtl/ts_activity_watch.sv
module ts_activity_watch
    import ts_mon_pkg::*;
#(
    parameter int RUN_LIMIT = 2040
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    output logic in_loss
);

    localparam int RW = $clog2(RUN_LIMIT + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(RUN_LIMIT);

    act_state_t    state, nxt;
    logic [RW-1:0] run, run_n;
    logic          last_bit;
    logic          toggled;

    assign toggled = (run == '0) || (bit_in != last_bit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ACT_LIVE;
            run      <= '0;
            last_bit <= 1'b0;
        end else begin
            state <= nxt;
            run   <= run_n;
            if (bit_vld) last_bit <= bit_in;
        end
    end

    always_comb begin
        run_n = run;
        if (bit_vld) begin
            if (toggled)             run_n = RW'(1);
            else if (run != RUN_MAX) run_n = run + RW'(1);
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ACT_LIVE: if (bit_vld && run_n == RUN_MAX) nxt = ACT_LOST;
            ACT_LOST: if (bit_vld && run_n != RUN_MAX) nxt = ACT_LIVE;
        endcase
    end

    always_comb in_loss = (state == ACT_LOST);

    AST_LOSS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ACT_LOST && !(bit_vld && bit_in != last_bit)) |=> (state == ACT_LOST)); // R8

    AST_LOSS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ACT_LOST && bit_vld && bit_in != last_bit) |=> (state == ACT_LIVE)); // R8

endmodule

// File: rtl/ts_indicator_hold.sv
module ts_indicator_hold
    import ts_mon_pkg::*;
#(
    parameter int HOLD_CYCLES = 15_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic err_in,
    output logic led_out
);

    localparam int TW = $clog2(HOLD_CYCLES + 1);
    localparam logic [TW-1:0] LOAD_C = TW'(HOLD_CYCLES - 2);

    hld_state_t    state, nxt;
    logic [TW-1:0] tmr, tmr_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HLD_FAULT;
            tmr   <= '0;
        end else begin
            state <= nxt;
            tmr   <= tmr_n;
        end
    end

    always_comb begin
        nxt   = state;
        tmr_n = tmr;
        unique case (state)
            HLD_QUIET: if (err_in) nxt = HLD_FAULT;
            HLD_FAULT: begin
                if (!err_in) begin
                    nxt   = HLD_TAIL;
                    tmr_n = LOAD_C;
                end
            end
            HLD_TAIL: begin
                if (err_in)          nxt = HLD_FAULT;
                else if (tmr == '0)  nxt = HLD_QUIET;
                else                 tmr_n = tmr - TW'(1);
            end
            default: nxt = HLD_FAULT;
        endcase
    end

    always_comb led_out = err_in || (state != HLD_QUIET);

    AST_TAIL_LIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_in) |-> led_out); // R6

    AST_ERR_LIT: assert property (@(posedge clk) disable iff (!rst_n)
        err_in |-> led_out); // R6

endmodule

// File: rtl/ts_health_monitor.sv
module ts_health_monitor #(
    parameter logic [7:0] SYNC_BYTE   = 8'h47,
    parameter int         LEN_SHORT   = 188,
    parameter int         LEN_LONG    = 204,
    parameter int         MISS_LIMIT  = 2,
    parameter int         HIT_LIMIT   = 5,
    parameter int         RUN_LIMIT   = 2040,
    parameter int         HOLD_CYCLES = 15_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    input  logic       bit_vld,
    input  logic       bit_in,
    output logic       ind_188,
    output logic       ind_204,
    output logic       ind_sync_err,
    output logic       ind_in_loss,
    output logic       alarm,
    output logic       line_oe
);

    logic sync_err;
    logic locked;
    logic span_long;
    logic in_loss;
    logic healthy;

    ts_sync_tracker #(
        .SYNC_BYTE (SYNC_BYTE),
        .LEN_SHORT (LEN_SHORT),
        .LEN_LONG  (LEN_LONG),
        .MISS_LIMIT(MISS_LIMIT),
        .HIT_LIMIT (HIT_LIMIT)
    ) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .sync_err (sync_err),
        .locked   (locked),
        .span_long(span_long)
    );

    ts_activity_watch #(
        .RUN_LIMIT(RUN_LIMIT)
    ) u_act (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_vld(bit_vld),
        .bit_in (bit_in),
        .in_loss(in_loss)
    );

    ts_indicator_hold #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_hld (
        .clk    (clk),
        .rst_n  (rst_n),
        .err_in (sync_err),
        .led_out(ind_sync_err)
    );

    always_comb begin
        healthy     = locked && !sync_err && !in_loss;
        ind_188     = healthy && !span_long;
        ind_204     = healthy && span_long;
        ind_in_loss = in_loss;
        alarm       = sync_err || in_loss;
        line_oe     = !in_loss;
    end

    AST_LOSS_DROPS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ind_in_loss) |-> (!line_oe && alarm)); // R10

    AST_LEN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ind_188 && ind_204)); // R2

endmodule

// File: tb/sim_ts_health_monitor.sv
module sim_ts_health_monitor;

    localparam int HOLD = 20;
    localparam int RUNL = 2040;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       ind_188, ind_204, ind_sync_err, ind_in_loss, alarm, line_oe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ts_health_monitor #(.HOLD_CYCLES(HOLD), .RUN_LIMIT(RUNL)) u0 (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .bit_vld(bit_vld), .bit_in(bit_in), .ind_188(ind_188), .ind_204(ind_204),
        .ind_sync_err(ind_sync_err), .ind_in_loss(ind_in_loss), .alarm(alarm),
        .line_oe(line_oe)
    );

    // {long packet, corrupt sync, expected error, expected 188, expected 204}
    localparam int ROWS = 16;
    localparam logic [4:0] VEC [ROWS] = '{
        5'b00100, 5'b00100, 5'b00100, 5'b00100, 5'b00100,
        5'b00010, 5'b01010, 5'b00010, 5'b01010, 5'b01100,
        5'b10100, 5'b10100, 5'b10100, 5'b10100, 5'b10100,
        5'b10001
    };

    task automatic check(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        byte_vld = 1'b1;
        byte_in  = b;
    endtask

    task automatic idle();
        @(negedge clk);
        byte_vld = 1'b0;
        bit_vld  = 1'b0;
    endtask

    task automatic send_packet(input int len, input logic bad);
        put_byte(bad ? 8'h00 : 8'h47);
        for (int k = 1; k < len; k++) put_byte(8'hA5);
        idle();
    endtask

    task automatic send_bits(input logic v, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bit_vld = 1'b1;
            bit_in  = v;
        end
        idle();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog run did not finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R12 reset state
        check(alarm, 1'b1, "R12", "alarm");
        check(ind_sync_err, 1'b1, "R12", "ind_sync_err");
        check(ind_188, 1'b0, "R12", "ind_188");
        check(ind_204, 1'b0, "R12", "ind_204");
        check(ind_in_loss, 1'b0, "R12", "ind_in_loss");
        check(line_oe, 1'b1, "R12", "line_oe");

        // Table: R1 reference, R2/R3 spacing, R4 raise, R5 clear, R9 alarm
        for (int i = 0; i < ROWS; i++) begin
            send_packet(VEC[i][4] ? 204 : 188, VEC[i][3]);
            check(alarm, VEC[i][2], "R4_R5_R9", $sformatf("row %0d alarm", i));
            check(ind_sync_err, VEC[i][2], "R6", $sformatf("row %0d led", i));
            check(ind_188, VEC[i][1], "R2", $sformatf("row %0d ind_188", i));
            check(ind_204, VEC[i][0], "R3", $sformatf("row %0d ind_204", i));
        end

        // R7 threshold, R10, R11, R8 saturation and clear
        send_bits(1'b1, RUNL - 1);
        check(ind_in_loss, 1'b0, "R7", "loss below limit");
        check(line_oe, 1'b1, "R10", "oe below limit");
        send_bits(1'b1, 1);
        check(ind_in_loss, 1'b1, "R7", "loss at limit");
        check(line_oe, 1'b0, "R10", "oe during loss");
        check(alarm, 1'b1, "R9", "alarm during loss");
        check(ind_204, 1'b0, "R11", "ind_204 during loss");
        send_bits(1'b1, 60);
        check(ind_in_loss, 1'b1, "R8", "loss past counter wrap point");
        send_bits(1'b0, 1);
        check(ind_in_loss, 1'b0, "R8", "loss cleared by transition");
        check(line_oe, 1'b1, "R10", "oe restored");
        check(ind_204, 1'b1, "R11", "ind_204 restored");
        check(alarm, 1'b0, "R9", "alarm restored");

        // Zero-run also detected
        send_bits(1'b0, RUNL);
        check(ind_in_loss, 1'b1, "R7", "loss on zeros");
        send_bits(1'b1, 1);

        // R6 hold stretch timing
        do_reset();
        for (int p = 0; p < 5; p++) send_packet(188, 1'b0);
        check(alarm, 1'b1, "R5", "four hits do not clear");
        put_byte(8'h47);
        idle();
        check(alarm, 1'b0, "R5", "fifth hit clears");
        check(ind_sync_err, 1'b1, "R6", "led lit after clear");
        check(ind_188, 1'b1, "R2", "ind_188 after clear");
        repeat (HOLD - 1) @(posedge clk);
        @(negedge clk);
        check(ind_sync_err, 1'b1, "R6", "led lit last hold cycle");
        @(posedge clk);
        @(negedge clk);
        check(ind_sync_err, 1'b0, "R6", "led dark after hold");

        // R1 non-0x47 value never taken as reference
        do_reset();
        for (int p = 0; p < 7; p++) begin
            put_byte(8'hB8);
            for (int k = 1; k < 188; k++) put_byte(8'hA5);
        end
        idle();
        check(alarm, 1'b1, "R1", "no lock on other byte value");
        check(ind_188, 1'b0, "R1", "no 188 on other byte value");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule